// File: doc/BRIEF.md
# Test Pattern Sequencer

This block walks a program of sequence steps held in an external step memory and turns each step into a run of test vectors. A step names the first vector address, how many vectors it runs, how many clocks each vector lasts and which timing set applies, plus a flow command. The flow commands are: go on to the next step, jump, conditional jump, loop, subroutine call, return, pause and halt. Each step's word is read through a plain combinational address/data port (`seq_addr` out, `seq_word` in), so the memory itself stays outside the block.

Six trigger inputs start, stop, pause, resume, redirect and halt the program. Each trigger is individually set to be edge (rising) or level sensitive. A single loop counter serves the loop command and can also be told to loop forever. A single-level return register serves subroutines. The status outputs report activity, pause, subroutine state, loop completion, return, the final step and errors.

Top module: `pat_seq`

## Requirements
- R1: After a synchronous reset the block is idle: `idle_active`=1, `seq_addr`=0, and `seq_active`, `paused`, `gosub_active`, `sub_return`, `loop_done`, `last_step`, `nest_err`, `tmo_flag` and `vec_strobe` are all 0.
- R2: Trigger bit order in `trg_in`/`trg_edge` is 0 run, 1 stop, 2 pause, 3 resume, 4 jump, 5 halt. A `trg_edge` bit of 1 makes that trigger fire on a rising input edge; 0 makes it fire on every clock where it is high. A run event while idle starts at step 0 on the next clock. It also clears the subroutine state, the loop counter, the pending triggers, the timer, `tmo_flag` and `nest_err`.
- R3: The step word is packed from MSB to LSB as: cont(1), loop_n(16), target(12), cond(3), cmd(3), tset(6), cpv(8), pat(26), vstart(24). Each vector lasts cpv+1 clocks. A step runs pat+1 vectors. `vec_addr` = vstart + vector index. `vec_strobe` is high on the first clock of each vector while running. `tset_out` follows the step's tset.
- R4: At the end of a step's last vector the cmd decides the next step. The codes are 0 next (step+1), 1 jump (target), 2 conditional jump (target if the condition holds, else step+1). The cond codes are 0 `err_in` high, 1 `tmo_flag` set, 2 `cond_sig` high, 3 `cond_sig` low, 4 a rising edge of `cond_sig` during the step, 5 a falling edge during the step. Codes 6 and 7 never hold.
- R5: cmd 3 is loop. With cont=1 it always goes back to target. Otherwise the span up to this step runs loop_n+1 times, returning to target each time before the last. On the final pass it goes on to step+1, and `loop_done` pulses for one clock.
- R6: cmd 4 is call. It saves step+1 and goes to target, and `gosub_active` goes high. cmd 5 is return: inside a subroutine it goes to the saved step, clears `gosub_active` and pulses `sub_return`; outside one it acts as next. A call made while `gosub_active` is high goes on to step+1 and sets the sticky `nest_err`.
- R7: cmd 6 moves to step+1 and pauses. A pause trigger pauses at the end of the current vector. While paused, the step and vector position are held. A resume event then continues from the next vector.
- R8: cmd 7 is halt: after its last vector the block goes idle. `last_step` is high while a halt step runs. A halt trigger is held pending and ends the run at the end of the current step, taking priority over any command.
- R9: A stop event while running or paused makes the block idle on the next clock.
- R10: A jump trigger is held pending. At the end of the current vector it moves the program to step `jump_tgt`, vector 0, and overrides the step's command.
- R11: `tmo_flag` sets once the block has spent `tmo_limit` clocks running since the last start. Paused clocks do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trg_in | input | 6 | Trigger inputs: run, stop, pause, resume, jump, halt |
| trg_edge | input | 6 | Per trigger: 1 rising edge, 0 level |
| cond_sig | input | 1 | Signal tested by level/edge conditions |
| err_in | input | 1 | Error condition input |
| jump_tgt | input | 12 | Step used by the jump trigger |
| tmo_limit | input | 32 | Running clocks before timeout |
| seq_addr | output | 12 | Current step address to step memory |
| seq_word | input | 99 | Step word at `seq_addr` |
| vec_addr | output | 24 | Current vector address |
| tset_out | output | 6 | Current timing set |
| vec_strobe | output | 1 | First clock of a vector |
| seq_active | output | 1 | Running or paused |
| idle_active | output | 1 | Idle |
| paused | output | 1 | Paused |
| gosub_active | output | 1 | Inside a subroutine |
| sub_return | output | 1 | One-clock pulse on a return |
| loop_done | output | 1 | One-clock pulse when a counted loop ends |
| last_step | output | 1 | A halt step is running |
| nest_err | output | 1 | Sticky nested-call error |
| tmo_flag | output | 1 | Timeout reached |

## Verification
A wrong vector or clock counter shows up on `vec_strobe` and `vec_addr` within one vector period. A wrong step choice shows on `seq_addr` on the clock after the step ends. A miscounted loop shows as a missing or early `loop_done` pulse and an extra or missing revisit of the loop target. A corrupted return register shows as a wrong `seq_addr` right after the return. The reference model tracks every output on every clock, so any divergence is reported on the clock where it first appears.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
    localparam int STEP_W = 12;
    localparam int VA_W   = 24;
    localparam int PAT_W  = 26;
    localparam int CPV_W  = 8;
    localparam int TS_W   = 6;
    localparam int LOOP_W = 16;
    localparam int TMO_W  = 32;
    localparam int N_TRG  = 6;

    localparam int TRG_RUN    = 0;
    localparam int TRG_STOP   = 1;
    localparam int TRG_PAUSE  = 2;
    localparam int TRG_RESUME = 3;
    localparam int TRG_JUMP   = 4;
    localparam int TRG_HALT   = 5;

    typedef enum logic [2:0] {
        CMD_NEXT, CMD_JUMP, CMD_CJUMP, CMD_LOOP,
        CMD_CALL, CMD_RET, CMD_PAUSE, CMD_HALT
    } cmd_e;

    localparam logic [2:0] CND_ERR  = 3'd0;
    localparam logic [2:0] CND_TMO  = 3'd1;
    localparam logic [2:0] CND_HIGH = 3'd2;
    localparam logic [2:0] CND_LOW  = 3'd3;
    localparam logic [2:0] CND_RISE = 3'd4;
    localparam logic [2:0] CND_FALL = 3'd5;

    typedef struct packed {
        logic              cont;
        logic [LOOP_W-1:0] loop_n;
        logic [STEP_W-1:0] target;
        logic [2:0]        cond;
        cmd_e              cmd;
        logic [TS_W-1:0]   tset;
        logic [CPV_W-1:0]  cpv;
        logic [PAT_W-1:0]  pat;
        logic [VA_W-1:0]   vstart;
    } step_t;

    localparam int WORD_W = $bits(step_t);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PAUSE} sstate_e;

    function automatic logic cond_true(input logic [2:0] c, input logic err,
                                       input logic tmo, input logic lvl,
                                       input logic rise, input logic fall);
        case (c)
            CND_ERR:  return err;
            CND_TMO:  return tmo;
            CND_HIGH: return lvl;
            CND_LOW:  return !lvl;
            CND_RISE: return rise;
            CND_FALL: return fall;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/pseq_trig.sv
module pseq_trig #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] trg_in,
    input  logic [N-1:0] trg_edge,
    output logic [N-1:0] ev
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= trg_in;
    end

    for (genvar g = 0; g < N; g++) begin : g_trg
        assign ev[g] = trg_edge[g] ? (trg_in[g] & ~prev_q[g]) : trg_in[g];
    end
endmodule

// File: rtl/pseq_cond.sv
module pseq_cond
    import pseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sig,
    input  logic       clr,
    input  logic [2:0] cond,
    input  logic       err,
    input  logic       tmo,
    output logic       hit
);
    logic prev_q, rise_seen_q, fall_seen_q;
    logic rise, fall;

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
    assign hit  = cond_true(cond, err, tmo, sig, rise_seen_q | rise, fall_seen_q | fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= 1'b0;
            rise_seen_q <= 1'b0;
            fall_seen_q <= 1'b0;
        end else begin
            prev_q      <= sig;
            rise_seen_q <= clr ? 1'b0 : (rise_seen_q | rise);
            fall_seen_q <= clr ? 1'b0 : (fall_seen_q | fall);
        end
    end
endmodule

// File: rtl/pseq_loop.sv
module pseq_loop
    import pseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take,
    input  logic              cont,
    input  logic [LOOP_W-1:0] loop_n,
    output logic              back,
    output logic              done
);
    logic              armed_q;
    logic [LOOP_W-1:0] cnt_q;
    logic [LOOP_W-1:0] rem;

    assign rem  = armed_q ? cnt_q : loop_n;
    assign back = cont | (rem != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (take && !cont) begin
                if (rem == '0) begin
                    armed_q <= 1'b0;
                    done    <= 1'b1;
                end else begin
                    armed_q <= 1'b1;
                    cnt_q   <= rem - 1'b1;
                end
            end
        end
    end

    // R5
    loop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/pat_seq.sv
module pat_seq
    import pseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRG-1:0]  trg_in,
    input  logic [N_TRG-1:0]  trg_edge,
    input  logic              cond_sig,
    input  logic              err_in,
    input  logic [STEP_W-1:0] jump_tgt,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic [STEP_W-1:0] seq_addr,
    input  logic [WORD_W-1:0] seq_word,
    output logic [VA_W-1:0]   vec_addr,
    output logic [TS_W-1:0]   tset_out,
    output logic              vec_strobe,
    output logic              seq_active,
    output logic              idle_active,
    output logic              paused,
    output logic              gosub_active,
    output logic              sub_return,
    output logic              loop_done,
    output logic              last_step,
    output logic              nest_err,
    output logic              tmo_flag
);
    sstate_e           state_q;
    logic [STEP_W-1:0] step_q, ret_q, seq_next;
    logic [PAT_W-1:0]  vidx_q;
    logic [CPV_W-1:0]  ccnt_q;
    logic [TMO_W-1:0]  timer_q;
    logic              in_sub_q, hpend_q, jpend_q, ppend_q, tmo_q, nest_q, sret_q;
    logic [N_TRG-1:0]  ev;
    step_t             w;
    logic              run, end_vec, end_step, do_halt, do_jump, do_pause;
    logic              hit, back, start, step_chg, loop_take;
    logic              call_ok, ret_ok, nest;

    pseq_trig #(.N(N_TRG)) u_trig (
        .clk(clk), .rst(rst), .trg_in(trg_in), .trg_edge(trg_edge), .ev(ev));

    pseq_cond u_cond (
        .clk(clk), .rst(rst), .sig(cond_sig), .clr(step_chg || state_q == ST_IDLE),
        .cond(w.cond), .err(err_in), .tmo(tmo_q), .hit(hit));

    pseq_loop u_loop (
        .clk(clk), .rst(rst), .clr(start), .take(loop_take), .cont(w.cont),
        .loop_n(w.loop_n), .back(back), .done(loop_done));

    always_comb begin
        w        = step_t'(seq_word);
        run      = (state_q == ST_RUN);
        end_vec  = run && (ccnt_q == w.cpv);
        end_step = end_vec && (vidx_q == w.pat);
        do_halt  = hpend_q || ev[TRG_HALT] || (w.cmd == CMD_HALT);
        do_jump  = jpend_q || ev[TRG_JUMP];
        do_pause = ppend_q || ev[TRG_PAUSE];
        start    = (state_q == ST_IDLE) && ev[TRG_RUN] && !ev[TRG_STOP];
        step_chg = end_step || (end_vec && do_jump);
        loop_take = end_step && !do_halt && !do_jump && (w.cmd == CMD_LOOP);
        seq_next = step_q + 1'b1;
        call_ok  = 1'b0;
        ret_ok   = 1'b0;
        nest     = 1'b0;
        case (w.cmd)
            CMD_JUMP:  seq_next = w.target;
            CMD_CJUMP: if (hit) seq_next = w.target;
            CMD_LOOP:  if (back) seq_next = w.target;
            CMD_CALL:  if (in_sub_q) nest = 1'b1;
                       else begin call_ok = 1'b1; seq_next = w.target; end
            CMD_RET:   if (in_sub_q) begin ret_ok = 1'b1; seq_next = ret_q; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            step_q   <= '0;
            ret_q    <= '0;
            vidx_q   <= '0;
            ccnt_q   <= '0;
            timer_q  <= '0;
            in_sub_q <= 1'b0;
            hpend_q  <= 1'b0;
            jpend_q  <= 1'b0;
            ppend_q  <= 1'b0;
            tmo_q    <= 1'b0;
            nest_q   <= 1'b0;
            sret_q   <= 1'b0;
        end else begin
            sret_q <= 1'b0;
            if (ev[TRG_STOP] && state_q != ST_IDLE) begin
                state_q <= ST_IDLE;
                hpend_q <= 1'b0;
                jpend_q <= 1'b0;
                ppend_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: if (start) begin
                        state_q  <= ST_RUN;
                        step_q   <= '0;
                        vidx_q   <= '0;
                        ccnt_q   <= '0;
                        in_sub_q <= 1'b0;
                        hpend_q  <= 1'b0;
                        jpend_q  <= 1'b0;
                        ppend_q  <= 1'b0;
                        timer_q  <= '0;
                        tmo_q    <= 1'b0;
                        nest_q   <= 1'b0;
                    end
                    ST_PAUSE: if (ev[TRG_RESUME]) state_q <= ST_RUN;
                    default: begin
                        if (timer_q != '1) timer_q <= timer_q + 1'b1;
                        tmo_q   <= tmo_q || ({1'b0, timer_q} + 1'b1 >= {1'b0, tmo_limit});
                        hpend_q <= hpend_q || ev[TRG_HALT];
                        jpend_q <= jpend_q || ev[TRG_JUMP];
                        ppend_q <= ppend_q || ev[TRG_PAUSE];
                        if (!end_vec) begin
                            ccnt_q <= ccnt_q + 1'b1;
                        end else begin
                            ccnt_q <= '0;
                            if (end_step) begin
                                vidx_q  <= '0;
                                hpend_q <= 1'b0;
                                jpend_q <= 1'b0;
                                ppend_q <= 1'b0;
                                if (do_halt) begin
                                    state_q <= ST_IDLE;
                                end else begin
                                    if (do_jump) begin
                                        step_q <= jump_tgt;
                                    end else begin
                                        step_q <= seq_next;
                                        if (call_ok) begin
                                            ret_q    <= step_q + 1'b1;
                                            in_sub_q <= 1'b1;
                                        end
                                        if (ret_ok) begin
                                            in_sub_q <= 1'b0;
                                            sret_q   <= 1'b1;
                                        end
                                        if (nest) nest_q <= 1'b1;
                                    end
                                    if (do_pause || w.cmd == CMD_PAUSE) state_q <= ST_PAUSE;
                                end
                            end else begin
                                if (do_jump) begin
                                    step_q  <= jump_tgt;
                                    vidx_q  <= '0;
                                    jpend_q <= 1'b0;
                                end else begin
                                    vidx_q <= vidx_q + 1'b1;
                                end
                                if (do_pause) begin
                                    state_q <= ST_PAUSE;
                                    ppend_q <= 1'b0;
                                end
                            end
                        end
                    end
                endcase
            end
        end
    end

    assign seq_addr     = step_q;
    assign vec_addr     = w.vstart + vidx_q[VA_W-1:0];
    assign tset_out     = w.tset;
    assign vec_strobe   = run && (ccnt_q == '0);
    assign seq_active   = (state_q != ST_IDLE);
    assign idle_active  = (state_q == ST_IDLE);
    assign paused       = (state_q == ST_PAUSE);
    assign gosub_active = in_sub_q;
    assign sub_return   = sret_q;
    assign last_step    = run && (w.cmd == CMD_HALT);
    assign nest_err     = nest_q;
    assign tmo_flag     = tmo_q;

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev[TRG_STOP] |=> idle_active);
    // R6
    ret_clears_chk: assert property (@(posedge clk) disable iff (rst)
        sub_return |-> !gosub_active);
    // R7
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (paused && !ev[TRG_RESUME] && !ev[TRG_STOP]) |=> ($stable(seq_addr) && $stable(vidx_q) && paused));
    // R3
    strobe_run_chk: assert property (@(posedge clk) disable iff (rst)
        vec_strobe |-> (seq_active && !paused));
    // R6
    nest_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (nest_err && !ev[TRG_RUN]) |=> nest_err);
endmodule

// File: tb/pat_seq_bench.sv
module pat_seq_bench;
    import pseq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_TRG-1:0]  trg_in = '0;
    logic [N_TRG-1:0]  trg_edge = '1;
    logic              cond_sig = 1'b0;
    logic              err_in = 1'b0;
    logic [STEP_W-1:0] jump_tgt = '0;
    logic [TMO_W-1:0]  tmo_limit = 32'd100000;
    logic [STEP_W-1:0] seq_addr;
    logic [WORD_W-1:0] seq_word;
    logic [VA_W-1:0]   vec_addr;
    logic [TS_W-1:0]   tset_out;
    logic vec_strobe, seq_active, idle_active, paused, gosub_active;
    logic sub_return, loop_done, last_step, nest_err, tmo_flag;

    step_t mem [16];
    assign seq_word = mem[seq_addr[3:0]];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pat_seq u_pat_seq (
        .clk(clk), .rst(rst), .trg_in(trg_in), .trg_edge(trg_edge),
        .cond_sig(cond_sig), .err_in(err_in), .jump_tgt(jump_tgt),
        .tmo_limit(tmo_limit), .seq_addr(seq_addr), .seq_word(seq_word),
        .vec_addr(vec_addr), .tset_out(tset_out), .vec_strobe(vec_strobe),
        .seq_active(seq_active), .idle_active(idle_active), .paused(paused),
        .gosub_active(gosub_active), .sub_return(sub_return),
        .loop_done(loop_done), .last_step(last_step), .nest_err(nest_err),
        .tmo_flag(tmo_flag));

    function automatic step_t mk(cmd_e c, logic [2:0] cnd, int tgt, int ln,
                                 bit cont, int pat, int cpv, int ts, int vs);
        step_t s;
        s.cont = cont; s.loop_n = LOOP_W'(ln); s.target = STEP_W'(tgt);
        s.cond = cnd; s.cmd = c; s.tset = TS_W'(ts); s.cpv = CPV_W'(cpv);
        s.pat = PAT_W'(pat); s.vstart = VA_W'(vs);
        return s;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    // Behavioural reference model
    int     m_state, m_step, m_vi, m_cc, m_ret, m_lcnt;
    bit     m_in_sub, m_larm, m_tmo, m_nest, m_ld, m_sr, m_hp, m_jp, m_pp;
    bit     m_rseen, m_fseen, m_sprev;
    longint m_timer;
    bit     m_prev [N_TRG];

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_state = 0; m_step = 0; m_vi = 0; m_cc = 0; m_ret = 0; m_lcnt = 0;
            m_in_sub = 0; m_larm = 0; m_tmo = 0; m_nest = 0; m_ld = 0; m_sr = 0;
            m_hp = 0; m_jp = 0; m_pp = 0; m_rseen = 0; m_fseen = 0; m_sprev = 0;
            m_timer = 0;
            for (int i = 0; i < N_TRG; i++) m_prev[i] = 0;
        end else begin
            step_t w;
            bit ev [N_TRG];
            bit rise, fall, hit, endv, ends, dh, dj, dp, clr;
            int rem;
            w = mem[m_step % 16];
            for (int i = 0; i < N_TRG; i++)
                ev[i] = trg_edge[i] ? (trg_in[i] && !m_prev[i]) : trg_in[i];
            rise = cond_sig && !m_sprev;
            fall = !cond_sig && m_sprev;
            case (w.cond)
                0: hit = err_in;
                1: hit = m_tmo;
                2: hit = cond_sig;
                3: hit = !cond_sig;
                4: hit = m_rseen || rise;
                5: hit = m_fseen || fall;
                default: hit = 0;
            endcase
            endv = (m_state == 1) && (m_cc == int'(w.cpv));
            ends = endv && (m_vi == int'(w.pat));
            dh = m_hp || ev[TRG_HALT] || (w.cmd == CMD_HALT);
            dj = m_jp || ev[TRG_JUMP];
            dp = m_pp || ev[TRG_PAUSE];
            clr = ends || (endv && dj) || (m_state == 0);
            m_rseen = clr ? 0 : (m_rseen || rise);
            m_fseen = clr ? 0 : (m_fseen || fall);
            m_ld = 0; m_sr = 0;
            if (ev[TRG_STOP] && m_state != 0) begin
                m_state = 0; m_hp = 0; m_jp = 0; m_pp = 0;
            end else if (m_state == 0) begin
                if (ev[TRG_RUN]) begin
                    m_state = 1; m_step = 0; m_vi = 0; m_cc = 0; m_in_sub = 0;
                    m_hp = 0; m_jp = 0; m_pp = 0; m_timer = 0; m_tmo = 0;
                    m_nest = 0; m_larm = 0;
                end
            end else if (m_state == 2) begin
                if (ev[TRG_RESUME]) m_state = 1;
            end else begin
                m_timer++;
                if (m_timer >= longint'(tmo_limit)) m_tmo = 1;
                m_hp |= ev[TRG_HALT]; m_jp |= ev[TRG_JUMP]; m_pp |= ev[TRG_PAUSE];
                if (!endv) m_cc++;
                else begin
                    m_cc = 0;
                    if (ends) begin
                        m_vi = 0; m_hp = 0; m_jp = 0; m_pp = 0;
                        if (dh) m_state = 0;
                        else begin
                            if (dj) m_step = int'(jump_tgt);
                            else begin
                                case (w.cmd)
                                    CMD_JUMP:  m_step = int'(w.target);
                                    CMD_CJUMP: m_step = hit ? int'(w.target) : (m_step + 1) % 4096;
                                    CMD_LOOP: begin
                                        rem = m_larm ? m_lcnt : int'(w.loop_n);
                                        if (w.cont) m_step = int'(w.target);
                                        else if (rem == 0) begin
                                            m_step = (m_step + 1) % 4096; m_larm = 0; m_ld = 1;
                                        end else begin
                                            m_lcnt = rem - 1; m_larm = 1; m_step = int'(w.target);
                                        end
                                    end
                                    CMD_CALL:
                                        if (m_in_sub) begin m_nest = 1; m_step = (m_step + 1) % 4096; end
                                        else begin
                                            m_ret = (m_step + 1) % 4096; m_in_sub = 1; m_step = int'(w.target);
                                        end
                                    CMD_RET:
                                        if (m_in_sub) begin m_step = m_ret; m_in_sub = 0; m_sr = 1; end
                                        else m_step = (m_step + 1) % 4096;
                                    default: m_step = (m_step + 1) % 4096;
                                endcase
                            end
                            if (dp || w.cmd == CMD_PAUSE) m_state = 2;
                        end
                    end else begin
                        if (dj) begin m_step = int'(jump_tgt); m_vi = 0; m_jp = 0; end
                        else m_vi++;
                        if (dp) begin m_state = 2; m_pp = 0; end
                    end
                end
            end
            for (int i = 0; i < N_TRG; i++) m_prev[i] = trg_in[i];
            m_sprev = cond_sig;
        end
    end

    // Compare every output against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            step_t e;
            e = mem[m_step % 16];
            chk(seq_addr == STEP_W'(m_step), "R4", "seq_addr", seq_addr, m_step);
            chk(vec_addr == VA_W'(int'(e.vstart) + m_vi), "R3", "vec_addr", vec_addr, VA_W'(int'(e.vstart) + m_vi));
            chk(tset_out == e.tset, "R3", "tset_out", tset_out, e.tset);
            chk(vec_strobe == (m_state == 1 && m_cc == 0), "R3", "vec_strobe", vec_strobe, (m_state == 1 && m_cc == 0));
            chk(seq_active == (m_state != 0), "R2", "seq_active", seq_active, (m_state != 0));
            chk(idle_active == (m_state == 0), "R2", "idle_active", idle_active, (m_state == 0));
            chk(paused == (m_state == 2), "R7", "paused", paused, (m_state == 2));
            chk(gosub_active == m_in_sub, "R6", "gosub_active", gosub_active, m_in_sub);
            chk(sub_return == m_sr, "R6", "sub_return", sub_return, m_sr);
            chk(loop_done == m_ld, "R5", "loop_done", loop_done, m_ld);
            chk(last_step == (m_state == 1 && e.cmd == CMD_HALT), "R8", "last_step", last_step, (m_state == 1 && e.cmd == CMD_HALT));
            chk(nest_err == m_nest, "R6", "nest_err", nest_err, m_nest);
            chk(tmo_flag == m_tmo, "R11", "tmo_flag", tmo_flag, m_tmo);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse(int idx);
        trg_in[idx] = 1'b1;
        tick(1);
        trg_in[idx] = 1'b0;
    endtask

    task automatic wait_paused(string req);
        int k = 0;
        while (!paused && k < 500) begin tick(1); k++; end
        chk(paused == 1'b1, req, "reached pause", paused, 1);
    endtask

    task automatic wait_idle(string req);
        int k = 0;
        while (!idle_active && k < 500) begin tick(1); k++; end
        chk(idle_active == 1'b1, req, "reached idle", idle_active, 1);
    endtask

    initial begin
        mem[0]  = mk(CMD_NEXT,  CND_ERR,  0, 0, 0, 1, 1, 1, 100);
        mem[1]  = mk(CMD_LOOP,  CND_ERR,  1, 2, 0, 0, 0, 2, 200);
        mem[2]  = mk(CMD_CALL,  CND_ERR,  8, 0, 0, 0, 2, 3, 300);
        mem[3]  = mk(CMD_CJUMP, CND_HIGH, 5, 0, 0, 2, 0, 4, 400);
        mem[4]  = mk(CMD_NEXT,  CND_ERR,  0, 0, 0, 0, 0, 5, 500);
        mem[5]  = mk(CMD_PAUSE, CND_ERR,  0, 0, 0, 3, 1, 6, 600);
        mem[6]  = mk(CMD_CALL,  CND_ERR,  8, 0, 0, 0, 0, 7, 700);
        mem[7]  = mk(CMD_HALT,  CND_ERR,  0, 0, 0, 1, 0, 8, 800);
        mem[8]  = mk(CMD_CALL,  CND_ERR, 10, 0, 0, 0, 0, 9, 900);
        mem[9]  = mk(CMD_RET,   CND_ERR,  0, 0, 0, 1, 1, 10, 1000);
        mem[10] = mk(CMD_HALT,  CND_ERR,  0, 0, 0, 0, 0, 11, 1100);
        mem[11] = mk(CMD_LOOP,  CND_ERR, 11, 0, 1, 0, 0, 12, 1200);
        mem[12] = mk(CMD_CJUMP, CND_RISE, 14, 0, 0, 3, 2, 13, 1300);
        mem[13] = mk(CMD_HALT,  CND_ERR,  0, 0, 0, 0, 0, 14, 1400);
        mem[14] = mk(CMD_HALT,  CND_ERR,  0, 0, 0, 0, 0, 15, 1500);
        mem[15] = mk(CMD_CJUMP, CND_TMO,  7, 0, 0, 1, 1, 16, 1600);

        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(idle_active == 1'b1 && seq_addr == '0, "R1", "idle after reset", idle_active, 1);
        chk({seq_active, paused, gosub_active, sub_return, loop_done, last_step, nest_err, tmo_flag, vec_strobe} == '0,
            "R1", "flags after reset", {seq_active, paused, gosub_active, sub_return, loop_done, last_step, nest_err, tmo_flag, vec_strobe}, 0);

        // Main program: loop, nested call, conditional fall-through, pause command
        pulse(TRG_RUN);
        chk(seq_active == 1'b1, "R2", "run edge starts", seq_active, 1);
        wait_paused("R7");
        tick(4);
        pulse(TRG_RESUME);
        wait_idle("R8");

        // Condition high taken, stop while paused
        cond_sig = 1'b1;
        pulse(TRG_RUN);
        wait_paused("R4");
        pulse(TRG_STOP);
        chk(idle_active == 1'b1, "R9", "stop from pause", idle_active, 1);

        // Jump trigger into continuous loop, pause/resume triggers, halt trigger
        cond_sig = 1'b0;
        jump_tgt = 12'd11;
        pulse(TRG_RUN);
        pulse(TRG_JUMP);
        tick(4);
        chk(seq_addr == 12'd11, "R10", "jump trigger target", seq_addr, 11);
        tick(10);
        chk(seq_addr == 12'd11 && seq_active, "R5", "continuous loop holds", seq_addr, 11);
        pulse(TRG_PAUSE);
        tick(3);
        chk(paused == 1'b1, "R7", "pause trigger", paused, 1);
        pulse(TRG_RESUME);
        tick(3);
        pulse(TRG_HALT);
        tick(2);
        chk(idle_active == 1'b1, "R8", "halt trigger", idle_active, 1);

        // Rising edge during a step taken, then not taken
        jump_tgt = 12'd12;
        pulse(TRG_RUN);
        pulse(TRG_JUMP);
        tick(4);
        cond_sig = 1'b1;
        tick(1);
        cond_sig = 1'b0;
        wait_idle("R4");
        pulse(TRG_RUN);
        pulse(TRG_JUMP);
        wait_idle("R4");

        // Timeout condition
        tmo_limit = 32'd3;
        jump_tgt = 12'd15;
        pulse(TRG_RUN);
        pulse(TRG_JUMP);
        wait_idle("R11");

        // Stop while running
        tmo_limit = 32'd100000;
        pulse(TRG_RUN);
        tick(2);
        pulse(TRG_STOP);
        chk(idle_active == 1'b1, "R9", "stop while running", idle_active, 1);

        // Level-sensitive run held high restarts after halt
        trg_edge[TRG_RUN] = 1'b0;
        trg_in[TRG_RUN] = 1'b1;
        wait_paused("R2");
        pulse(TRG_RESUME);
        tick(40);
        trg_in[TRG_RUN] = 1'b0;
        pulse(TRG_STOP);
        tick(2);
        chk(idle_active == 1'b1, "R2", "idle after level run", idle_active, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #3000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule